// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block turns two system-level conditions into a clean, stretched reset for the rest of the chip. The first condition is a single-bit flag, already synchronous to the block clock, that reports the supply rail as being below its threshold. The second is an active-low manual request, which may come straight from a mechanical push-button or from other logic. The manual request is synchronized and debounced inside the block.

While either condition is active, reset is held asserted. Once the last active condition goes away, reset is held for a fixed number of clock cycles before it releases. That number defaults to 200 ms at the configured clock rate. If any condition returns during that hold, the hold starts again from zero. Two reset outputs are provided: an active-low one and its exact active-high complement. A supervisor watchdog has no direct path into this block. To make a watchdog timeout cause a reset, route its output onto the manual input.

Top module: `sup_reset_gen`

## Requirements
- R1: While `supply_low_i` is 1 at a clock edge, `sys_rst_n_o` is 0 after that edge, and it stays 0 for every cycle in which the flag stays 1.
- R2: When `man_rst_n_i` goes to 0 and stays there, `sys_rst_n_o` is 0 starting DEB_CYCLES+3 clock edges after the input changed (2 synchronizer stages, DEB_CYCLES stable samples, 1 hold register).
- R3: After the last edge at which `supply_low_i` is sampled as 1, with no other trigger present, `sys_rst_n_o` returns to 1 exactly HOLD_CYCLES edges later.
- R4: After `man_rst_n_i` returns to 1 and stays there, `sys_rst_n_o` returns to 1 exactly DEB_CYCLES+2+HOLD_CYCLES edges after the input changed.
- R5: A change of `man_rst_n_i` that lasts fewer than DEB_CYCLES consecutive synchronized samples is ignored. Switch bounce of this kind neither starts a reset nor shortens or extends one.
- R6: `sys_rst_o` always equals the inverse of `sys_rst_n_o`.
- R7: Reset has no trigger other than the two inputs. With `supply_low_i` = 0 and `man_rst_n_i` = 1, the outputs stay released indefinitely. A watchdog therefore resets the system only by being wired to `man_rst_n_i`.
- R8: A trigger that appears during the hold period restarts the hold count from zero.
- R9: While `por_n_i` is 0, `sys_rst_n_o` is 0. After `por_n_i` rises with both triggers idle, `sys_rst_n_o` stays 0 for HOLD_CYCLES more edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| por_n_i | input | 1 | Asynchronous power-on initialization, active low |
| supply_low_i | input | 1 | Synchronous supply-below-threshold flag, active high |
| man_rst_n_i | input | 1 | Manual reset request, active low, asynchronous and possibly bouncing |
| sys_rst_n_o | output | 1 | System reset, active low |
| sys_rst_o | output | 1 | System reset, active high, inverse of sys_rst_n_o |

## Verification
The supply flag takes effect one edge after it is sampled. A manual change takes effect DEB_CYCLES+3 edges after it arrives. Releases come HOLD_CYCLES edges after the last trigger sample. The bench builds this timing into a reference model that advances on each rising edge. It compares both outputs against that model at the following falling edge, so every sample sits half a period away from the edge that produced it. Directed phases cover power-up, supply pulses, clean and bouncing manual presses, and retriggers during the hold. A seeded random phase then mixes both inputs.

// File: rtl/sup_reset_pkg.sv
package sup_reset_pkg;

    // Default timing: 50 MHz clock, 200 ms hold, 10 ms debounce window.
    localparam int unsigned DEF_CLK_HZ      = 50_000_000;
    localparam int unsigned DEF_HOLD_CYCLES = DEF_CLK_HZ / 5;
    localparam int unsigned DEF_DEB_CYCLES  = DEF_CLK_HZ / 100;

    // Two synchronizer stages for an asynchronous level.
    typedef struct packed {
        logic meta;
        logic sync;
    } sync_pair_t;

endpackage

// File: rtl/sup_mr_debounce.sv
module sup_mr_debounce
    import sup_reset_pkg::*;
#(
    parameter int unsigned DEB_CYCLES = DEF_DEB_CYCLES
) (
    input  logic clk_i,
    input  logic por_n_i,
    input  logic raw_n_i,
    output logic clean_n_o
);
    localparam int unsigned DW = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
    localparam logic [DW-1:0] DLAST = DW'(DEB_CYCLES - 1);

    typedef struct packed {
        sync_pair_t    pipe;
        logic          stable;
        logic [DW-1:0] run;
    } deb_state_t;

    deb_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.pipe.meta = raw_n_i;
        st_d.pipe.sync = st_q.pipe.meta;
        if (st_q.pipe.sync != st_q.stable) begin
            if (st_q.run == DLAST) begin
                st_d.stable = st_q.pipe.sync;
                st_d.run    = '0;
            end else begin
                st_d.run = st_q.run + 1'b1;
            end
        end else begin
            st_d.run = '0;
        end
    end

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) begin
            st_q.pipe   <= '{meta: 1'b1, sync: 1'b1};
            st_q.stable <= 1'b1;
            st_q.run    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clean_n_o = st_q.stable;

    // The debounced level changes only toward a synchronized level that differed from it.
    assert_deb_follows_R5: assert property (@(posedge clk_i) disable iff (!por_n_i)
        !$stable(st_q.stable) |-> ($past(st_q.pipe.sync) == st_q.stable));

    // The run counter only grows while the synchronized level disagrees.
    assert_deb_run_R5: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (st_q.run != '0) |-> (st_q.pipe.sync != st_q.stable || $past(st_q.pipe.sync) != $past(st_q.stable)));

endmodule

// File: rtl/sup_hold_timer.sv
module sup_hold_timer
    import sup_reset_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = DEF_HOLD_CYCLES
) (
    input  logic clk_i,
    input  logic por_n_i,
    input  logic trig_i,
    output logic active_o
);
    localparam int unsigned HW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [HW-1:0] HLAST = HW'(HOLD_CYCLES - 1);

    typedef struct packed {
        logic          active;
        logic [HW-1:0] cnt;
    } hold_state_t;

    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig_i) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active) begin
            if (st_q.cnt == HLAST) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) begin
            st_q.active <= 1'b1;
            st_q.cnt    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;

    // A trigger restarts the hold from zero with reset asserted.
    assert_hold_restart_R8: assert property (@(posedge clk_i) disable iff (!por_n_i)
        trig_i |=> (st_q.active && st_q.cnt == '0));

    // Release happens only at the end of a full count with no trigger present.
    assert_hold_release_R3: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $fell(st_q.active) |-> ($past(st_q.cnt) == HLAST && !$past(trig_i)));

    // The counter stays inside its range.
    assert_hold_bound_R3: assert property (@(posedge clk_i) disable iff (!por_n_i)
        st_q.cnt <= HLAST);

endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen
    import sup_reset_pkg::*;
#(
    parameter int unsigned CLK_HZ      = DEF_CLK_HZ,
    parameter int unsigned HOLD_CYCLES = CLK_HZ / 5,
    parameter int unsigned DEB_CYCLES  = CLK_HZ / 100
) (
    input  logic clk_i,
    input  logic por_n_i,
    input  logic supply_low_i,
    input  logic man_rst_n_i,
    output logic sys_rst_n_o,
    output logic sys_rst_o
);
    logic man_clean_n;
    logic trig;
    logic hold_active;

    sup_mr_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
        .clk_i    (clk_i),
        .por_n_i  (por_n_i),
        .raw_n_i  (man_rst_n_i),
        .clean_n_o(man_clean_n)
    );

    // Only the supply flag and the debounced manual request can trigger.
    assign trig = supply_low_i | ~man_clean_n;

    sup_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk_i   (clk_i),
        .por_n_i (por_n_i),
        .trig_i  (trig),
        .active_o(hold_active)
    );

    assign sys_rst_n_o = ~hold_active;
    assign sys_rst_o   = hold_active;

    assert_supply_holds_R1: assert property (@(posedge clk_i) disable iff (!por_n_i)
        supply_low_i |=> !sys_rst_n_o);

    assert_manual_holds_R2: assert property (@(posedge clk_i) disable iff (!por_n_i)
        !man_clean_n |=> !sys_rst_n_o);

    assert_no_other_trigger_R7: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (sys_rst_n_o && !supply_low_i && man_clean_n) |=> sys_rst_n_o);

    always_comb begin
        assert_outputs_inverse_R6: assert (sys_rst_o !== sys_rst_n_o);
    end

endmodule

// File: tb/sup_reset_gen_bench.sv
module sup_reset_gen_bench;
    localparam int unsigned HOLD = 20;
    localparam int unsigned DEB  = 4;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic sup = 1'b0;
    logic man_n = 1'b1;
    logic rst_n, rst;

    int n_checks = 0;
    int n_fail   = 0;
    string phase = "R9";
    bit done = 1'b0;

    always #5 clk = ~clk;

    sup_reset_gen #(.CLK_HZ(100), .HOLD_CYCLES(HOLD), .DEB_CYCLES(DEB)) u_sup_reset_gen (
        .clk_i       (clk),
        .por_n_i     (por_n),
        .supply_low_i(sup),
        .man_rst_n_i (man_n),
        .sys_rst_n_o (rst_n),
        .sys_rst_o   (rst)
    );

    // Reference model from the requirements: two-edge delay on the manual
    // input, DEB consecutive agreeing samples to accept a new level, and
    // release once HOLD edges have passed with no trigger sampled.
    logic m_d1 = 1'b1, m_d2 = 1'b1, m_acc = 1'b1;
    int   m_agree = 0;
    int   m_age = 0;

    function automatic logic exp_rst_n(int age);
        return (age >= int'(HOLD));
    endfunction

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_d1 = 1'b1; m_d2 = 1'b1; m_acc = 1'b1; m_agree = 0; m_age = 0;
        end else begin
            logic trig_now;
            trig_now = sup | ~m_acc;
            if (m_d2 != m_acc) begin
                m_agree++;
                if (m_agree == int'(DEB)) begin
                    m_acc = m_d2;
                    m_agree = 0;
                end
            end else begin
                m_agree = 0;
            end
            m_d2 = m_d1;
            m_d1 = man_n;
            if (trig_now) m_age = 0;
            else if (m_age < int'(HOLD)) m_age++;
        end
    end

    task automatic check(input bit ok, input string tag, input logic act, input logic expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, expv, $time);
        end
    endtask

    // Sample away from the rising edge, before inputs change.
    always @(negedge clk) begin
        if (!done) begin
            logic e;
            e = por_n ? exp_rst_n(m_age) : 1'b0;
            check(rst_n === e, phase, rst_n, e);
            check(rst === ~rst_n, "R6", rst, ~rst_n);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    initial begin
        fork
            begin
                #2_000_000;
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual hung expected finish");
                done = 1'b1;
                $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
                $finish;
            end
        join_none

        // R9: power-up
        cyc(5);
        por_n = 1'b1;
        cyc(HOLD + 5);

        // R7: idle for a long stretch
        phase = "R7";
        cyc(60);

        // R1 / R3: supply pulse
        phase = "R1"; sup = 1'b1; cyc(7);
        phase = "R3"; sup = 1'b0; cyc(HOLD + 4);

        // R2 / R4: clean manual press
        phase = "R2"; man_n = 1'b0; cyc(DEB + 10);
        phase = "R4"; man_n = 1'b1; cyc(DEB + HOLD + 5);

        // R5: short glitches ignored, bounce on press
        phase = "R5";
        for (int k = 0; k < 6; k++) begin
            man_n = 1'b0; cyc(DEB - 1);
            man_n = 1'b1; cyc(3);
        end
        cyc(10);
        man_n = 1'b0; cyc(2); man_n = 1'b1; cyc(1); man_n = 1'b0; cyc(DEB + 8);
        man_n = 1'b1; cyc(1); man_n = 1'b0; cyc(2); man_n = 1'b1; cyc(DEB + HOLD + 6);

        // R8: retrigger during hold
        phase = "R8";
        sup = 1'b1; cyc(2); sup = 1'b0; cyc(HOLD / 2);
        sup = 1'b1; cyc(1); sup = 1'b0; cyc(HOLD - 3);
        sup = 1'b1; cyc(1); sup = 1'b0; cyc(HOLD + 4);

        // Random mix
        phase = "R1";
        begin
            int unsigned seed;
            seed = 32'h5eed_1234;
            void'($urandom(seed));
        end
        for (int k = 0; k < 400; k++) begin
            int unsigned r;
            r = $urandom;
            if ((r & 32'hF) == 0) sup = ~sup;
            if (((r >> 4) & 32'h7) == 0) man_n = ~man_n;
            if (sup && ((r >> 8) & 32'h3) == 0) sup = 1'b0;
            cyc(1 + int'((r >> 12) & 32'h7));
        end
        sup = 1'b0; man_n = 1'b1;
        phase = "R4";
        cyc(DEB + HOLD + 10);

        // Mid-run power-on initialization: R9
        phase = "R9";
        por_n = 1'b0; cyc(3);
        por_n = 1'b1; cyc(HOLD + 4);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule